// File: doc/BRIEF.md
# Overcurrent Hiccup Controller

This block is the digital fault supervisor of a synchronous step-down converter. Once per switching period it judges whether the high-side switch was turned on and, if so, whether that pulse was cut short by the high-side current limit. Limited pulses accumulate in a small event counter. A run of clean pulses that is long enough clears that counter. When the counter overflows, the block enters hiccup. In hiccup it holds both power switches off and discharges the soft-start node, and it stays there for a fixed number of switching periods. It then asks the startup sequencer for a fresh soft-start.

The controller sees three digital inputs from the modulator: a one-clock period tick that closes each switching period, a one-clock strobe when the high-side switch turns on, and a flag that is high while the current limit is tripped. It judges the converter the same way during soft-start and during steady regulation. A global enable clears all of its state at once.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `hiccup_active` and `restart_req` are 0.
- R2: A period closes at the clock edge that samples `period_tick` high. It is a limited period if `hs_on` and `ilim_hit` were both seen at some cycle of it (the tick cycle included). Eight limited periods, with no completed clean run between them, make `hiccup_active` rise on the edge that closes the eighth.
- R3: A period with a turn-on and no limit is clean. Three consecutive clean periods clear the event count, so eight further limited periods are then needed to trip.
- R4: A limited period restarts the clean run but keeps the event count. For example, 5 limited, 2 clean and 3 limited periods trip on the last one.
- R5: A period without any `hs_on` strobe changes neither count, even when `ilim_hit` was high in it. Such a period does not break a clean run.
- R6: Hiccup lasts exactly WAIT_PERIODS period ticks (1024 by default) after entry. On the edge that samples the last of them, `hiccup_active` falls and `restart_req` is high for exactly one clock.
- R7: After a restart both counts start from zero.
- R8: While `hiccup_active` is 1, `hs_on` and `ilim_hit` have no effect. After the restart, eight new limited periods are still required.
- R9: `enable` low clears both counts and ends hiccup on the next edge, with no `restart_req` pulse.
- R10: A limit flag raised only in the tick cycle of a period with a turn-on still makes that period limited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low clears all state |
| period_tick | input | 1 | One-clock pulse closing each switching period |
| hs_on | input | 1 | One-clock strobe at high-side turn-on |
| ilim_hit | input | 1 | High-side current limit reached |
| hiccup_active | output | 1 | Switches held off and soft-start discharged |
| restart_req | output | 1 | One-clock request for a new soft-start |

## Verification
Both outputs are registered, so each result is due exactly one edge after the stimulus that causes it. The rise of `hiccup_active` follows the tick that closes the eighth limited period. Its fall and the `restart_req` pulse follow the 1024th tick of the wait. Clearing by `enable` takes effect on the first edge that samples it low. The bench drives inputs on falling edges. It updates a behavioural reference on each rising edge from the inputs the design also sampled, and compares both outputs on every falling edge, so each comparison sees the state one edge after its cause.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

  // Verdict on one switching period, valid in its closing cycle
  typedef enum logic [1:0] {
    PER_NONE  = 2'd0,
    PER_CLEAN = 2'd1,
    PER_LIMIT = 2'd2
  } per_result_e;

  localparam int unsigned DEF_EVT_W        = 3;
  localparam int unsigned DEF_CLEAN_RUN    = 3;
  localparam int unsigned DEF_WAIT_PERIODS = 1024;

endpackage

// File: rtl/ocp_period_sampler.sv
module ocp_period_sampler
  import ocp_hiccup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        period_tick,
  input  logic        hs_on,
  input  logic        ilim_hit,
  output per_result_e result
);

  logic hs_seen_q, hs_seen_d;
  logic lim_seen_q, lim_seen_d;
  logic hs_any, lim_any;

  assign hs_any  = hs_seen_q | hs_on;
  assign lim_any = lim_seen_q | ilim_hit;

  always_comb begin
    result = PER_NONE;
    if (period_tick && !clr) begin
      if (hs_any) begin
        result = lim_any ? PER_LIMIT : PER_CLEAN;
      end
    end
  end

  always_comb begin
    if (clr || period_tick) begin
      hs_seen_d  = 1'b0;
      lim_seen_d = 1'b0;
    end else begin
      hs_seen_d  = hs_any;
      lim_seen_d = lim_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_seen_q  <= 1'b0;
      lim_seen_q <= 1'b0;
    end else begin
      hs_seen_q  <= hs_seen_d;
      lim_seen_q <= lim_seen_d;
    end
  end

  AST_NO_VERDICT_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !period_tick |-> result == PER_NONE) else $error("verdict without tick"); // R2

  AST_FLAGS_CLEARED_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !hs_seen_q && !lim_seen_q) else $error("flags kept across period"); // R5

endmodule

// File: rtl/ocp_event_counter.sv
module ocp_event_counter
  import ocp_hiccup_pkg::*;
#(
  parameter int unsigned EVT_W     = DEF_EVT_W,
  parameter int unsigned CLEAN_RUN = DEF_CLEAN_RUN
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  per_result_e result,
  output logic        trip
);

  localparam int unsigned CLEAN_W   = $clog2(CLEAN_RUN + 1);
  localparam logic [EVT_W-1:0]   EVT_FULL  = {EVT_W{1'b1}};
  localparam logic [CLEAN_W-1:0] CLEAN_END = CLEAN_W'(CLEAN_RUN - 1);

  logic [EVT_W-1:0]   evt_q, evt_d;
  logic [CLEAN_W-1:0] clean_q, clean_d;
  logic               upd_en;

  assign trip   = (result == PER_LIMIT) && (evt_q == EVT_FULL) && !clr;
  assign upd_en = clr || (result != PER_NONE);

  always_comb begin
    evt_d   = evt_q;
    clean_d = clean_q;
    if (clr || trip) begin
      evt_d   = '0;
      clean_d = '0;
    end else if (result == PER_LIMIT) begin
      evt_d   = evt_q + 1'b1;
      clean_d = '0;
    end else if (result == PER_CLEAN) begin
      if (clean_q == CLEAN_END) begin
        evt_d   = '0;
        clean_d = '0;
      end else begin
        clean_d = clean_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= '0;
      clean_q <= '0;
    end else if (upd_en) begin
      evt_q   <= evt_d;
      clean_q <= clean_d;
    end
  end

  AST_IDLE_PERIOD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (result == PER_NONE && !clr) |=> $stable(evt_q) && $stable(clean_q))
    else $error("count moved in idle period"); // R5

  AST_CLEAN_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (result == PER_CLEAN && clean_q == CLEAN_END && !clr) |=> evt_q == '0)
    else $error("clean run did not clear"); // R3

  AST_LIMIT_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (result == PER_LIMIT && !clr) |=> clean_q == '0)
    else $error("limit kept clean run"); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> evt_q == '0 && clean_q == '0) else $error("clear ignored"); // R9

endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer
  import ocp_hiccup_pkg::*;
#(
  parameter int unsigned WAIT_PERIODS = DEF_WAIT_PERIODS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic period_tick,
  input  logic trip,
  output logic hiccup_active,
  output logic restart_req
);

  localparam int unsigned WAIT_W = $clog2(WAIT_PERIODS + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_PERIODS - 1);

  logic              hic_q, hic_d;
  logic              rs_q, rs_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              wait_done;

  assign wait_done = hic_q && period_tick && (wait_q == WAIT_LAST);

  always_comb begin
    hic_d  = hic_q;
    rs_d   = 1'b0;
    wait_d = wait_q;
    if (!enable) begin
      hic_d  = 1'b0;
      wait_d = '0;
    end else if (hic_q) begin
      if (wait_done) begin
        hic_d  = 1'b0;
        rs_d   = 1'b1;
        wait_d = '0;
      end else if (period_tick) begin
        wait_d = wait_q + 1'b1;
      end
    end else if (trip) begin
      hic_d  = 1'b1;
      wait_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hic_q  <= 1'b0;
      rs_q   <= 1'b0;
      wait_q <= '0;
    end else begin
      hic_q  <= hic_d;
      rs_q   <= rs_d;
      wait_q <= wait_d;
    end
  end

  assign hiccup_active = hic_q;
  assign restart_req   = rs_q;

  AST_TRIP_ENTERS_HICCUP: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && enable && !hic_q) |=> hic_q) else $error("trip ignored"); // R2

  AST_HICCUP_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (hic_q && enable && !period_tick) |=> hic_q) else $error("hiccup left early"); // R6

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
  import ocp_hiccup_pkg::*;
#(
  parameter int unsigned EVT_W        = DEF_EVT_W,
  parameter int unsigned CLEAN_RUN    = DEF_CLEAN_RUN,
  parameter int unsigned WAIT_PERIODS = DEF_WAIT_PERIODS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic period_tick,
  input  logic hs_on,
  input  logic ilim_hit,
  output logic hiccup_active,
  output logic restart_req
);

  per_result_e per_result;
  logic        hold_clr;
  logic        trip;

  // Counting is frozen and flushed while disabled or waiting out a hiccup
  assign hold_clr = !enable || hiccup_active;

  ocp_period_sampler u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (hold_clr),
    .period_tick (period_tick),
    .hs_on       (hs_on),
    .ilim_hit    (ilim_hit),
    .result      (per_result)
  );

  ocp_event_counter #(
    .EVT_W     (EVT_W),
    .CLEAN_RUN (CLEAN_RUN)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (hold_clr),
    .result (per_result),
    .trip   (trip)
  );

  ocp_hiccup_timer #(
    .WAIT_PERIODS (WAIT_PERIODS)
  ) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .period_tick   (period_tick),
    .trip          (trip),
    .hiccup_active (hiccup_active),
    .restart_req   (restart_req)
  );

  AST_RESTART_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req) else $error("restart too long"); // R6

  AST_RESTART_ENDS_HICCUP: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> !hiccup_active && $past(hiccup_active)) else $error("stray restart"); // R6

  AST_DISABLE_CLEARS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !hiccup_active && !restart_req) else $error("disable ignored"); // R9

endmodule

// File: tb/ocp_hiccup_ctrl_bench.sv
module ocp_hiccup_ctrl_bench;

  localparam int WAITP = 1024;
  localparam int PLEN  = 4;

  logic clk = 1'b0;
  logic rst_n, enable, period_tick, hs_on, ilim_hit;
  logic hiccup_active, restart_req;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // reference state
  int  m_evt = 0, m_clean = 0, m_wait = 0;
  bit  m_hs = 0, m_lim = 0, m_hic = 0, m_rs = 0;

  always #4 clk = ~clk;

  ocp_hiccup_ctrl u_ocp_hiccup_ctrl (
    .clk (clk), .rst_n (rst_n), .enable (enable), .period_tick (period_tick),
    .hs_on (hs_on), .ilim_hit (ilim_hit),
    .hiccup_active (hiccup_active), .restart_req (restart_req)
  );

  // behavioural reference, advanced on the same edge as the design
  always @(posedge clk) begin
    bit hs_a, lim_a;
    if (!rst_n || !enable) begin
      m_evt = 0; m_clean = 0; m_wait = 0;
      m_hs = 0; m_lim = 0; m_hic = 0; m_rs = 0;
    end else if (m_hic) begin
      m_rs = 0; m_hs = 0; m_lim = 0;
      if (period_tick) begin
        m_wait++;
        if (m_wait == WAITP) begin
          m_hic = 0; m_rs = 1; m_wait = 0; m_evt = 0; m_clean = 0;
        end
      end
    end else begin
      m_rs = 0;
      hs_a = m_hs | hs_on;
      lim_a = m_lim | ilim_hit;
      if (period_tick) begin
        m_hs = 0; m_lim = 0;
        if (hs_a && lim_a) begin
          m_clean = 0;
          m_evt++;
          if (m_evt == 8) begin
            m_hic = 1; m_evt = 0; m_wait = 0;
          end
        end else if (hs_a) begin
          m_clean++;
          if (m_clean == 3) begin m_clean = 0; m_evt = 0; end
        end
      end else begin
        m_hs = hs_a; m_lim = lim_a;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (hiccup_active !== m_hic) begin
      miscompares++;
      $display("FAIL %s hiccup_active actual=%0b expected=%0b at %0t",
               cur_req, hiccup_active, m_hic, $time);
    end
    if (restart_req !== m_rs) begin
      miscompares++;
      $display("FAIL %s restart_req actual=%0b expected=%0b at %0t",
               cur_req, restart_req, m_rs, $time);
    end
  end

  // kind: 0 idle (no turn-on), 1 clean, 2 limited mid-period, 3 limit only in tick cycle,
  //       4 limit flag without turn-on
  task automatic run_period(input int kind);
    for (int k = 0; k < PLEN; k++) begin
      @(negedge clk);
      hs_on       = (kind >= 1 && kind <= 3 && k == 0);
      ilim_hit    = (kind == 2 && k == 1) || (kind == 3 && k == PLEN-1) || (kind == 4 && k == 1);
      period_tick = (k == PLEN-1);
    end
    @(negedge clk);
    hs_on = 0; ilim_hit = 0; period_tick = 0;
  endtask

  task automatic run_n(input int kind, input int n);
    for (int i = 0; i < n; i++) run_period(kind);
  endtask

  task automatic expect_hic(input bit exp, input string req);
    vectors++;
    if (hiccup_active !== exp) begin
      miscompares++;
      $display("FAIL %s hiccup_active actual=%0b expected=%0b", req, hiccup_active, exp);
    end
  endtask

  initial begin
    rst_n = 0; enable = 1; period_tick = 0; hs_on = 0; ilim_hit = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_hic(1'b0, "R1");

    cur_req = "R2";               // eight limited periods trip
    run_n(2, 7);
    expect_hic(1'b0, "R2");
    run_period(2);
    expect_hic(1'b1, "R2");

    cur_req = "R8";               // strobes during the wait are ignored
    run_n(2, 20);
    cur_req = "R6";
    run_n(1, WAITP - 20 - 1);
    expect_hic(1'b1, "R6");
    run_period(1);
    expect_hic(1'b0, "R6");

    cur_req = "R7";               // counts start from zero after restart
    run_n(2, 7);
    expect_hic(1'b0, "R7");

    cur_req = "R3";               // three clean periods clear
    run_n(1, 3);
    run_n(2, 7);
    expect_hic(1'b0, "R3");

    cur_req = "R10";              // limit seen only in the tick cycle
    run_period(3);
    expect_hic(1'b1, "R10");

    cur_req = "R9";               // disable ends hiccup without restart
    run_n(1, 5);
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;
    expect_hic(1'b0, "R9");
    run_n(2, 6);
    @(negedge clk); enable = 0;   // also clears counts
    @(negedge clk); enable = 1;
    run_n(2, 7);
    expect_hic(1'b0, "R9");
    run_n(1, 3);

    cur_req = "R5";               // idle periods change nothing, keep clean run
    run_n(2, 4);
    run_n(1, 2);
    run_n(4, 3);
    run_n(0, 2);
    run_period(1);                // completes the run of three
    run_n(2, 7);
    expect_hic(1'b0, "R5");
    run_n(4, 4);
    expect_hic(1'b0, "R5");
    run_period(2);
    expect_hic(1'b1, "R5");
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;

    cur_req = "R4";               // short clean run keeps count
    run_n(2, 5);
    run_n(1, 2);
    run_n(2, 2);
    expect_hic(1'b0, "R4");
    run_period(2);
    expect_hic(1'b1, "R4");
    run_n(0, WAITP);
    expect_hic(1'b0, "R6");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule